// File: doc/BRIEF.md
# SPI Transfer Control Sequencer

This block is the control unit that sits between a register bus and an SPI shift engine. It decides when a transfer runs and counts it down, and it reports when the transfer ends. Software writes word counts and a direction selection into a small register file. The sequencer then drives start, stop and direction commands into the shift engine. Each completed word is reported back by the engine as a one-cycle `eng_word_done` pulse, and the sequencer decrements its counters on those pulses.

Transmit and receive each have their own 20-bit word count. A receive-only auto-clock mode has its own 9-bit count and makes the engine clock in dummy words without any transmit data. A line configuration that needs an explicit software strobe (three-wire or dual-line operation) holds an armed transfer until that strobe arrives.

End-of-transmit and end-of-receive events feed raw, enable, masked and clear interrupt registers, which drive a single interrupt line. When DMA is enabled, the FIFO fill levels produce burst requests. A reset control bit drives the FIFO reset line.

Top module: `spi_xfer_seq`

Register map (word address on `wr_addr`/`rd_addr`):
- 0 CTRL: [1] transmit enable, [0] receive enable, [2] strobe-required line mode, [3] DMA enable.
- 1 TXHI: [3:0] high part of the transmit count.
- 2 TXLO: [15:0] low part of the transmit count. A write loads the counter and arms the transmit side.
- 3 RXHI and 4 RXLO: the same pair for the receive side.
- 5 RONLY: [8:0] receive-only count, [9] start.
- 6 REQ: write-only strobe. [1] requests transmit, [0] requests receive.
- 7 INTEN: interrupt enable.
- 8 INTCLR: interrupt clear, write 1 to clear.
- 9 INTRAW: raw interrupt status.
- 10 INTMSK: masked interrupt status.
- 11 STAT: [8] busy.
- 12 FIFORST: [0] FIFO reset.

In registers 7 to 10, bit 8 is the transmit-end event and bit 9 is the receive-end event.

## Requirements
- R1: After reset, `irq`, `eng_tx`, `eng_rx`, `eng_dummy`, `fifo_rst` and both DMA requests are 0, and INTRAW and the STAT busy bit read 0.
- R2: With CTRL[1] set, writing TXLO with a nonzero count {TXHI[3:0], TXLO[15:0]} starts a transmit. `eng_start` pulses and `eng_tx` rises. INTRAW bit 8 sets on exactly the word that brings the count to zero. A count of zero starts nothing.
- R3: Writing CTRL with bits [1:0] = 00 stops all activity at once. `eng_tx`, `eng_rx` and `eng_dummy` drop, and `eng_stop` pulses for one cycle.
- R4: With CTRL[1:0] = 01, a write to RONLY that sets the start bit while the stored start bit is 0, with a nonzero count, runs `eng_dummy` and `eng_rx` for that many words and then sets INTRAW bit 9. A start write made while the stored start bit is still 1 is ignored.
- R5: With CTRL[2] set, an armed transfer waits for its strobe. REQ bit 1 releases transmit and REQ bit 0 releases receive. A strobe for the other direction does not start it.
- R6: INTMSK equals INTRAW AND INTEN. `irq` is the OR of INTMSK. Writing 1 to an INTCLR bit clears that raw bit, and an event in the same cycle wins.
- R7: STAT bit 8 reads 1 while a transfer is counting or `eng_line_busy` is high. After the transmit-end event it drops only once `eng_line_busy` falls.
- R8: `fifo_rst` follows FIFORST[0]: writing 1 asserts it and writing 0 releases it.
- R9: With CTRL[3] set, `dma_tx_req` is high while transmit runs and the transmit FIFO has at least 8 free of 32 entries. `dma_rx_req` is high when the receive FIFO holds at least 8 words. Both are 0 when CTRL[3] is clear.
- R10: With CTRL[1:0] = 11, transmit and receive count down independently on the shared word pulses. Each raises its own end event when its own count reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| tx_level | input | 6 | Transmit FIFO fill level, 0 to 32 |
| rx_level | input | 6 | Receive FIFO fill level, 0 to 32 |
| eng_word_done | input | 1 | Engine finished one word |
| eng_line_busy | input | 1 | Engine is still shifting on the line |
| eng_start | output | 1 | One-cycle pulse when activity begins |
| eng_stop | output | 1 | One-cycle pulse when activity ends |
| eng_tx | output | 1 | Transmit direction active |
| eng_rx | output | 1 | Receive direction active |
| eng_dummy | output | 1 | Receive-only dummy clocking active |
| fifo_rst | output | 1 | FIFO reset line |
| dma_tx_req | output | 1 | Transmit DMA burst request |
| dma_rx_req | output | 1 | Receive DMA burst request |
| irq | output | 1 | Interrupt line |

## Verification
The hardest situation to reach is the end of a long transfer that uses the high part of the count. Only a count above 65535 proves that the four high bits reach the counter. The stimulus writes a high part of 1 and holds the word pulse for 65537 cycles, checks that no end event has appeared yet, and then gives the final word. The re-arm rule of the receive-only mode is another corner: the stored start bit is left at 1 after a completed run, and the rule is proved by trying a second start before clearing it.

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq #(
  parameter int DW    = 32,
  parameter int AW    = 4,
  parameter int LEN_W = 20,
  parameter int LO_W  = 16,
  parameter int RO_W  = 9,
  parameter int DEPTH = 32,
  parameter int BURST = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [DW-1:0]                wr_data,
  input  logic [AW-1:0]                rd_addr,
  output logic [DW-1:0]                rd_data,
  input  logic [$clog2(DEPTH+1)-1:0]   tx_level,
  input  logic [$clog2(DEPTH+1)-1:0]   rx_level,
  input  logic                         eng_word_done,
  input  logic                         eng_line_busy,
  output logic                         eng_start,
  output logic                         eng_stop,
  output logic                         eng_tx,
  output logic                         eng_rx,
  output logic                         eng_dummy,
  output logic                         fifo_rst,
  output logic                         dma_tx_req,
  output logic                         dma_rx_req,
  output logic                         irq
);
  localparam int HI_W  = LEN_W - LO_W;
  localparam int LVL_W = $clog2(DEPTH+1);
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_TXHI  = AW'(1);
  localparam logic [AW-1:0] A_TXLO  = AW'(2);
  localparam logic [AW-1:0] A_RXHI  = AW'(3);
  localparam logic [AW-1:0] A_RXLO  = AW'(4);
  localparam logic [AW-1:0] A_RONLY = AW'(5);
  localparam logic [AW-1:0] A_REQ   = AW'(6);
  localparam logic [AW-1:0] A_INTEN = AW'(7);
  localparam logic [AW-1:0] A_INTCL = AW'(8);
  localparam logic [AW-1:0] A_RAW   = AW'(9);
  localparam logic [AW-1:0] A_MSK   = AW'(10);
  localparam logic [AW-1:0] A_STAT  = AW'(11);
  localparam logic [AW-1:0] A_FRST  = AW'(12);

  logic [1:0]       mode_q;
  logic             need_req_q, dma_en_q, fifo_rst_q;
  logic [HI_W-1:0]  tx_hi, rx_hi;
  logic [RO_W:0]    ro_reg;
  logic [1:0]       int_en, raw;
  logic [LEN_W-1:0] tx_cnt, rx_cnt, tx_cnt_d, rx_cnt_d;
  logic [RO_W-1:0]  ro_cnt, ro_cnt_d;
  logic             tx_act, rx_act, ro_act, tx_pend, rx_pend;
  logic             tx_act_d, rx_act_d, ro_act_d, tx_pend_d, rx_pend_d;
  logic             start_q, stop_q;

  wire wr_ctrl  = wr_en && wr_addr == A_CTRL;
  wire wr_txlo  = wr_en && wr_addr == A_TXLO;
  wire wr_rxlo  = wr_en && wr_addr == A_RXLO;
  wire wr_ronly = wr_en && wr_addr == A_RONLY;
  wire wr_req   = wr_en && wr_addr == A_REQ;
  wire wr_clr   = wr_en && wr_addr == A_INTCL;
  wire go_idle  = wr_ctrl && wr_data[1:0] == 2'b00;

  wire [LEN_W-1:0] tx_len_new = {tx_hi, wr_data[LO_W-1:0]};
  wire [LEN_W-1:0] rx_len_new = {rx_hi, wr_data[LO_W-1:0]};

  wire arm_tx = wr_txlo && mode_q[1] && !tx_act && !tx_pend && tx_len_new != '0;
  wire arm_rx = wr_rxlo && mode_q[0] && !rx_act && !rx_pend && rx_len_new != '0;
  wire req_tx = wr_req && wr_data[1] && tx_pend;
  wire req_rx = wr_req && wr_data[0] && rx_pend;
  wire ro_arm = wr_ronly && wr_data[RO_W] && !ro_reg[RO_W] && mode_q == 2'b01 &&
                !ro_act && wr_data[RO_W-1:0] != '0;

  wire tx_dec  = eng_word_done && tx_act;
  wire rx_dec  = eng_word_done && rx_act;
  wire ro_dec  = eng_word_done && ro_act;
  wire tx_last = tx_dec && tx_cnt == LEN_W'(1) && !go_idle;
  wire rx_last = (rx_dec && rx_cnt == LEN_W'(1) && !go_idle) ||
                 (ro_dec && ro_cnt == RO_W'(1) && !go_idle);

  wire act_now = tx_act | rx_act | ro_act;
  wire act_nx  = tx_act_d | rx_act_d | ro_act_d;

  always_comb begin
    tx_act_d = tx_act; tx_pend_d = tx_pend; tx_cnt_d = tx_cnt;
    rx_act_d = rx_act; rx_pend_d = rx_pend; rx_cnt_d = rx_cnt;
    ro_act_d = ro_act; ro_cnt_d = ro_cnt;
    if (arm_tx) begin
      tx_cnt_d = tx_len_new;
      if (need_req_q) tx_pend_d = 1'b1;
      else tx_act_d = 1'b1;
    end else if (req_tx) begin
      tx_pend_d = 1'b0;
      tx_act_d = 1'b1;
    end else if (tx_dec) begin
      tx_cnt_d = tx_cnt - LEN_W'(1);
      if (tx_cnt == LEN_W'(1)) tx_act_d = 1'b0;
    end
    if (arm_rx) begin
      rx_cnt_d = rx_len_new;
      if (need_req_q) rx_pend_d = 1'b1;
      else rx_act_d = 1'b1;
    end else if (req_rx) begin
      rx_pend_d = 1'b0;
      rx_act_d = 1'b1;
    end else if (rx_dec) begin
      rx_cnt_d = rx_cnt - LEN_W'(1);
      if (rx_cnt == LEN_W'(1)) rx_act_d = 1'b0;
    end
    if (ro_arm) begin
      ro_cnt_d = wr_data[RO_W-1:0];
      ro_act_d = 1'b1;
    end else if (ro_dec) begin
      ro_cnt_d = ro_cnt - RO_W'(1);
      if (ro_cnt == RO_W'(1)) ro_act_d = 1'b0;
    end
    if (go_idle) begin
      tx_act_d = 1'b0; tx_pend_d = 1'b0; tx_cnt_d = '0;
      rx_act_d = 1'b0; rx_pend_d = 1'b0; rx_cnt_d = '0;
      ro_act_d = 1'b0; ro_cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; need_req_q <= 1'b0; dma_en_q <= 1'b0; fifo_rst_q <= 1'b0;
      tx_hi <= '0; rx_hi <= '0; ro_reg <= '0; int_en <= '0; raw <= '0;
      tx_cnt <= '0; rx_cnt <= '0; ro_cnt <= '0;
      tx_act <= 1'b0; rx_act <= 1'b0; ro_act <= 1'b0;
      tx_pend <= 1'b0; rx_pend <= 1'b0;
      start_q <= 1'b0; stop_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mode_q <= wr_data[1:0];
        need_req_q <= wr_data[2];
        dma_en_q <= wr_data[3];
      end
      if (wr_en && wr_addr == A_TXHI)  tx_hi <= wr_data[HI_W-1:0];
      if (wr_en && wr_addr == A_RXHI)  rx_hi <= wr_data[HI_W-1:0];
      if (wr_ronly)                    ro_reg <= wr_data[RO_W:0];
      if (wr_en && wr_addr == A_INTEN) int_en <= wr_data[9:8];
      if (wr_en && wr_addr == A_FRST)  fifo_rst_q <= wr_data[0];
      raw[0] <= tx_last | (raw[0] & ~(wr_clr & wr_data[8]));
      raw[1] <= rx_last | (raw[1] & ~(wr_clr & wr_data[9]));
      tx_cnt <= tx_cnt_d; rx_cnt <= rx_cnt_d; ro_cnt <= ro_cnt_d;
      tx_act <= tx_act_d; rx_act <= rx_act_d; ro_act <= ro_act_d;
      tx_pend <= tx_pend_d; rx_pend <= rx_pend_d;
      start_q <= !act_now && act_nx;
      stop_q  <= act_now && !act_nx;
    end
  end

  wire busy = act_now | eng_line_busy;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data[3:0] = {dma_en_q, need_req_q, mode_q};
      A_TXHI:  rd_data[HI_W-1:0] = tx_hi;
      A_RXHI:  rd_data[HI_W-1:0] = rx_hi;
      A_RONLY: rd_data[RO_W:0] = ro_reg;
      A_INTEN: rd_data[9:8] = int_en;
      A_RAW:   rd_data[9:8] = raw;
      A_MSK:   rd_data[9:8] = raw & int_en;
      A_STAT:  rd_data[8] = busy;
      A_FRST:  rd_data[0] = fifo_rst_q;
      default: rd_data = '0;
    endcase
  end

  assign eng_start  = start_q;
  assign eng_stop   = stop_q;
  assign eng_tx     = tx_act;
  assign eng_rx     = rx_act | ro_act;
  assign eng_dummy  = ro_act;
  assign fifo_rst   = fifo_rst_q;
  assign dma_tx_req = dma_en_q && tx_act &&
                      (LVL_W'(DEPTH) - tx_level) >= LVL_W'(BURST);
  assign dma_rx_req = dma_en_q && rx_level >= LVL_W'(BURST);
  assign irq        = |(raw & int_en);
endmodule

// File: rtl/spi_xfer_seq_chk.sv
module spi_xfer_seq_chk #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [1:0]    mode_q,
  input logic [1:0]    raw,
  input logic          tx_act,
  input logic          tx_last,
  input logic          dma_en_q,
  input logic          eng_start,
  input logic          eng_tx,
  input logic          eng_rx,
  input logic          dma_tx_req
);
  assert_txend_on_finish_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_act) && mode_q != 2'b00 |-> raw[0]);

  assert_idle_stops_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == AW'(0) && wr_data[1:0] == 2'b00 |=> !eng_tx && !eng_rx);

  assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == AW'(8) && wr_data[8] && !tx_last |=> !raw[0]);

  assert_dma_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tx_req |-> dma_en_q && eng_tx);

  assert_start_has_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> eng_tx || eng_rx);
endmodule

bind spi_xfer_seq spi_xfer_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .mode_q(mode_q), .raw(raw), .tx_act(tx_act), .tx_last(tx_last),
  .dma_en_q(dma_en_q), .eng_start(eng_start), .eng_tx(eng_tx), .eng_rx(eng_rx),
  .dma_tx_req(dma_tx_req)
);

// File: tb/sim_spi_xfer_seq.sv
`timescale 1ns/1ps
module sim_spi_xfer_seq;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [5:0]  tx_level = 0, rx_level = 0;
  logic        eng_word_done = 0, eng_line_busy = 0;
  logic        eng_start, eng_stop, eng_tx, eng_rx, eng_dummy;
  logic        fifo_rst, dma_tx_req, dma_rx_req, irq;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  spi_xfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_level(tx_level), .rx_level(rx_level),
    .eng_word_done(eng_word_done), .eng_line_busy(eng_line_busy),
    .eng_start(eng_start), .eng_stop(eng_stop), .eng_tx(eng_tx), .eng_rx(eng_rx),
    .eng_dummy(eng_dummy), .fifo_rst(fifo_rst), .dma_tx_req(dma_tx_req),
    .dma_rx_req(dma_rx_req), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic words(input int n);
    @(negedge clk);
    eng_word_done = 1;
    repeat (n) @(negedge clk);
    eng_word_done = 0;
  endtask

  task automatic to_idle();
    wr(0, 0);
    wr(8, 32'h300);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", irq, 0);
    check("R1 dir", {eng_tx, eng_rx, eng_dummy}, 0);
    check("R1 fifo_rst", fifo_rst, 0);
    check("R1 dma", {dma_tx_req, dma_rx_req}, 0);
    rd(9, v); check("R1 raw", v, 0);
    rd(11, v); check("R1 busy", v, 0);
  endtask

  task automatic t_tx_basic();
    logic [31:0] v;
    wr(0, 32'h2); wr(1, 0);
    wr(2, 0);
    check("R2 zero length ignored", eng_tx, 0);
    wr(2, 3);
    check("R2 start pulse", eng_start, 1);
    check("R2 tx active", eng_tx, 1);
    words(2);
    rd(9, v); check("R2 no end early", v, 0);
    words(1);
    rd(9, v); check("R2 tx end bit8", v, 32'h100);
    check("R2 tx dropped", eng_tx, 0);
    check("R6 irq masked off", irq, 0);
    rd(10, v); check("R6 masked zero", v, 0);
    wr(7, 32'h100);
    check("R6 irq on enable", irq, 1);
    rd(10, v); check("R6 masked bit8", v, 32'h100);
    wr(8, 32'h200);
    rd(9, v); check("R6 other clear no effect", v, 32'h100);
    wr(8, 32'h100);
    rd(9, v); check("R6 cleared", v, 0);
    check("R6 irq low", irq, 0);
    wr(7, 0);
    to_idle();
  endtask

  task automatic t_long();
    logic [31:0] v;
    wr(0, 32'h2); wr(1, 1); wr(2, 2);
    words(65537);
    rd(9, v); check("R2 long not yet", v, 0);
    check("R2 long still active", eng_tx, 1);
    words(1);
    rd(9, v); check("R2 long end", v, 32'h100);
    wr(1, 0);
    to_idle();
  endtask

  task automatic t_abort();
    wr(0, 32'h2); wr(2, 10);
    words(3);
    @(negedge clk);
    wr_en = 1; wr_addr = 0; wr_data = 0;
    @(negedge clk);
    wr_en = 0;
    check("R3 stop pulse", eng_stop, 1);
    check("R3 idle", {eng_tx, eng_rx, eng_dummy}, 0);
    @(negedge clk);
    check("R3 stop single", eng_stop, 0);
    to_idle();
  endtask

  task automatic t_rxonly();
    logic [31:0] v;
    wr(0, 32'h1);
    wr(5, 32'h205);
    check("R4 dummy on", {eng_dummy, eng_rx}, 2'b11);
    words(4);
    rd(9, v); check("R4 not yet", v, 0);
    words(1);
    rd(9, v); check("R4 rx end bit9", v, 32'h200);
    check("R4 dummy off", eng_dummy, 0);
    wr(8, 32'h200);
    wr(5, 32'h203);
    check("R4 rearm ignored", eng_dummy, 0);
    wr(5, 0);
    wr(5, 32'h203);
    check("R4 rearm after clear", eng_dummy, 1);
    words(3);
    rd(9, v); check("R4 second end", v, 32'h200);
    wr(5, 0);
    to_idle();
  endtask

  task automatic t_strobe();
    wr(0, 32'h6); wr(2, 2);
    check("R5 waits", eng_tx, 0);
    wr(6, 32'h1);
    check("R5 wrong strobe", eng_tx, 0);
    wr(6, 32'h2);
    check("R5 tx strobe starts", eng_tx, 1);
    to_idle();
    wr(0, 32'h5); wr(4, 2);
    check("R5 rx waits", eng_rx, 0);
    wr(6, 32'h1);
    check("R5 rx strobe starts", eng_rx, 1);
    to_idle();
  endtask

  task automatic t_busy();
    logic [31:0] v;
    eng_line_busy = 1;
    wr(0, 32'h2); wr(2, 1);
    words(1);
    rd(9, v); check("R7 end raised", v, 32'h100);
    rd(11, v); check("R7 busy held by line", v, 32'h100);
    @(negedge clk); eng_line_busy = 0; #1;
    rd(11, v); check("R7 busy drops", v, 0);
    to_idle();
  endtask

  task automatic t_fifo_dma();
    wr(12, 1); check("R8 reset asserted", fifo_rst, 1);
    wr(12, 0); check("R8 reset released", fifo_rst, 0);
    wr(0, 32'hA); wr(2, 100);
    tx_level = 24; #1; check("R9 tx req at 8 free", dma_tx_req, 1);
    tx_level = 25; #1; check("R9 tx req at 7 free", dma_tx_req, 0);
    rx_level = 8;  #1; check("R9 rx req", dma_rx_req, 1);
    rx_level = 7;  #1; check("R9 rx below burst", dma_rx_req, 0);
    rx_level = 8; tx_level = 0;
    wr(0, 32'h2); wr(2, 5);
    check("R9 dma disabled", {dma_tx_req, dma_rx_req}, 0);
    rx_level = 0;
    to_idle();
  endtask

  task automatic t_duplex();
    logic [31:0] v;
    wr(0, 32'h3); wr(2, 2); wr(4, 4);
    check("R10 both active", {eng_tx, eng_rx}, 2'b11);
    words(2);
    rd(9, v); check("R10 tx end first", v, 32'h100);
    check("R10 rx still active", eng_rx, 1);
    words(2);
    rd(9, v); check("R10 rx end", v, 32'h300);
    to_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_basic();
    t_abort();
    t_rxonly();
    t_strobe();
    t_busy();
    t_fifo_dma();
    t_duplex();
    t_long();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule